// File: doc/BRIEF.md
# Unaligned Quad-Word Load Buffer

This block serves a stream of 128-bit loads (four 32-bit words each) that may begin at any word address, while the memory behind it can only deliver quad-aligned 128-bit blocks. A stream is started with a word address and a quad count. The block then issues aligned quad reads at consecutive quad addresses and returns each memory quad one cycle after the read is issued. It keeps the older of two neighbouring aligned quads in a holding register. It joins that quad with the newer one and selects four words starting at the word offset, which gives each unaligned result.

Results leave on a valid/ready stream. Two returned quads can wait in a small queue. Reads are issued only when their data is sure to find room, so backpressure on the output slows the reads and loses nothing. Starting a new stream at any time drops the held quad, the queued quads and any read still in flight. The typical use is a filter walking its sample buffer from an arbitrary word position.

Top module: `qload_align`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `mem_rd_en` are 0.
- R2: When the start address has its low two bits at 0, result k equals the memory quad at quad address (start_addr/4 + k), with word i of the result in bits [32i+31:32i].
- R3: When the low two bits of the start address are nonzero, word i of result k equals memory word (start_addr + 4k + i), which is taken from the concatenation {newer quad, held quad}.
- R4: A stream of count N delivers exactly N results. It issues N reads for a zero offset and N+1 reads otherwise. The first read goes to quad address start_addr/4, and each later read goes to the next quad address.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle, unless a start intervenes.
- R6: A start discards all held, queued and in-flight data. No read is issued in the start cycle, and `out_valid` is 0 in the cycle after it. Only results of the new stream follow.
- R7: A start with count 0 produces no read and no result.
- R8: With `out_ready` held at 1, the N results of a stream appear on N consecutive cycles.
- R9: Word and quad addresses wrap modulo 2^ADDR_W words, so a stream that runs past the top of memory continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new stream; takes effect at once and aborts any current stream |
| start_addr | input | ADDR_W | Word address of the first result word |
| start_count | input | CNT_W | Number of 128-bit results to deliver |
| mem_rd_en | output | 1 | Aligned quad read strobe |
| mem_rd_addr | output | ADDR_W-2 | Quad address of the read |
| mem_rd_data | input | 4*WORD_W | Quad returned in the cycle after the read strobe |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 4*WORD_W | Result quad, word 0 in the low bits |

## Verification
The bench builds the block with ADDR_W = 12, WORD_W = 32 and CNT_W = 6. The 4096-word space is small enough that a stream started two words below the top crosses the wrap point within three results. The memory model gives every word a value derived from its address, so a wrong offset, a swapped half of the concatenation or a skipped quad changes the data that comes back. All four offsets are run with several ready patterns. The bench also restarts a stream while reads are still in flight.

// File: rtl/qload_align.sv
module qload_align #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [CNT_W-1:0]    start_count,
  output logic                mem_rd_en,
  output logic [ADDR_W-3:0]   mem_rd_addr,
  input  logic [4*WORD_W-1:0] mem_rd_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*WORD_W-1:0] out_data
);
  localparam int QW   = 4 * WORD_W;
  localparam int QA_W = ADDR_W - 2;

  logic [QA_W-1:0]  qaddr;
  logic [1:0]       off;
  logic [CNT_W:0]   reads_left;
  logic [CNT_W-1:0] outs_left;
  logic             pend;
  logic [QW-1:0]    q0, q1, held;
  logic             wp, rp, held_v;
  logic [1:0]       cnt;

  logic [QW-1:0]    front;
  logic [2*QW-1:0]  cat;
  logic             has, prime, fire, pop, push, issue;
  logic [2:0]       occ;

  assign front = rp ? q1 : q0;
  assign cat   = {front, held};
  assign has   = (cnt != 2'd0);
  assign prime = has && (off != 2'd0) && !held_v;
  assign out_valid = has && ((off == 2'd0) || held_v) && (outs_left != '0);
  assign fire  = out_valid && out_ready;
  assign pop   = prime || fire;
  assign push  = pend && !start;
  assign occ   = 3'(cnt) + 3'(pend) - 3'(pop);
  assign issue = !start && (reads_left != '0) && (occ < 3'd2);

  assign mem_rd_en   = issue;
  assign mem_rd_addr = qaddr;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      if (off == 2'd0)
        out_data[i*WORD_W +: WORD_W] = front[i*WORD_W +: WORD_W];
      else
        out_data[i*WORD_W +: WORD_W] = cat[(int'(off) + i)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qaddr      <= '0;
      off        <= '0;
      reads_left <= '0;
      outs_left  <= '0;
      pend       <= 1'b0;
      wp         <= 1'b0;
      rp         <= 1'b0;
      cnt        <= '0;
      held_v     <= 1'b0;
    end else if (start) begin
      qaddr      <= start_addr[ADDR_W-1:2];
      off        <= start_addr[1:0];
      outs_left  <= start_count;
      reads_left <= (CNT_W+1)'(start_count) +
                    (CNT_W+1)'((start_addr[1:0] != 2'd0) && (start_count != '0));
      pend       <= 1'b0;
      wp         <= 1'b0;
      rp         <= 1'b0;
      cnt        <= '0;
      held_v     <= 1'b0;
    end else begin
      pend <= issue;
      if (issue) begin
        qaddr      <= qaddr + QA_W'(1);
        reads_left <= reads_left - (CNT_W+1)'(1);
      end
      if (push) wp <= !wp;
      if (pop) begin
        rp     <= !rp;
        held_v <= 1'b1;
      end
      cnt <= cnt + 2'(push) - 2'(pop);
      if (fire) outs_left <= outs_left - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !wp) q0 <= mem_rd_data;
    if (push && wp)  q1 <= mem_rd_data;
    if (pop && !start) held <= front;
  end
endmodule

// File: rtl/qload_align_chk.sv
module qload_align_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [ADDR_W-1:0]   start_addr,
  input logic [CNT_W-1:0]    start_count,
  input logic                mem_rd_en,
  input logic [ADDR_W-3:0]   mem_rd_addr,
  input logic                out_valid,
  input logic                out_ready,
  input logic [4*WORD_W-1:0] out_data
);
  logic [CNT_W-1:0] lat, tally;
  logic [CNT_W:0]   rd_lat, rd_tally;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= '0; tally <= '0; rd_lat <= '0; rd_tally <= '0;
    end else if (start) begin
      lat      <= start_count;
      tally    <= '0;
      rd_lat   <= (CNT_W+1)'(start_count) +
                  (CNT_W+1)'((start_addr[1:0] != 2'd0) && (start_count != '0));
      rd_tally <= '0;
    end else begin
      if (out_valid && out_ready) tally <= tally + CNT_W'(1);
      if (mem_rd_en) rd_tally <= rd_tally + (CNT_W+1)'(1);
    end
  end

  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !mem_rd_en);

  a_r4_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == $past(mem_rd_addr) + 1'b1);

  a_r4_out_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !start |-> tally < lat);

  a_r4_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> rd_tally < rd_lat);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_data));

  a_r6_no_read_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !mem_rd_en);

  a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    start && start_count == '0 |=> !mem_rd_en && !out_valid);
endmodule

bind qload_align qload_align_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .start_count(start_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/qload_align_tb_top.sv
`timescale 1ns/1ps
module qload_align_tb_top;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 6;
  localparam int QW     = 4 * WORD_W;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  // {addr[27:16], count[15:8], ready pattern[7:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h0000_04FF, 32'h0005_05FF, 32'h000A_0355, 32'h000F_0433,
    32'h0100_060F, 32'h0FFE_03FF, 32'h0123_01FF, 32'h0040_0181
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  start_count = '0;
  logic mem_rd_en, out_valid;
  logic [ADDR_W-3:0] mem_rd_addr;
  logic [QW-1:0] mem_rd_data = '0, out_data;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  qload_align #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  function automatic logic [31:0] wv(input int a);
    logic [11:0] aa = 12'(a & AMASK);
    return {8'hA5, aa, aa * 12'd7};
  endfunction

  function automatic logic [QW-1:0] quad_at(input int wa);
    logic [QW-1:0] q;
    for (int i = 0; i < 4; i++) q[i*32 +: 32] = wv(wa + i);
    return q;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= quad_at(int'(mem_rd_addr) * 4);

  task automatic chk(input logic ok, input string tag, input logic [QW-1:0] act, input logic [QW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input int addr, input int count);
    @(negedge clk);
    out_ready = 1'b0; start = 1'b1;
    start_addr = ADDR_W'(addr); start_count = CNT_W'(count);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int addr, input int count, input logic [7:0] pat,
                         input int stop, input logic tail, input string dtag);
    int got = 0, rds = 0, first = -1, last = -1, extra = 0;
    logic hflag = 1'b0;
    logic [QW-1:0] hdat = '0;
    bit nz = (addr & 3) != 0;
    for (int j = 0; j < 300 && got < stop; j++) begin
      if (j > 0) @(negedge clk);
      out_ready = pat[j % 8];
      #1;
      if (hflag) chk(out_valid && out_data == hdat, "R5 hold under backpressure", out_data, hdat);
      if (mem_rd_en) begin
        if (rds == 0) chk(int'(mem_rd_addr) == ((addr & AMASK) >> 2), "R4 first read address",
                          QW'(mem_rd_addr), QW'((addr & AMASK) >> 2));
        rds++;
      end
      hflag = out_valid && !out_ready;
      hdat  = out_data;
      if (out_valid && out_ready) begin
        chk(out_data == quad_at(addr + 4 * got), dtag, out_data, quad_at(addr + 4 * got));
        if (first < 0) first = j;
        last = j;
        got++;
      end
    end
    chk(got == stop, "R4 result count reached", QW'(got), QW'(stop));
    if (tail) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        if (mem_rd_en) rds++;
        if (out_valid) extra++;
      end
      chk(extra == 0, "R4 no extra result", QW'(extra), '0);
      chk(rds == count + (nz ? 1 : 0), "R4 read count", QW'(rds), QW'(count + (nz ? 1 : 0)));
      if (pat == 8'hFF)
        chk(last - first == count - 1, "R8 back-to-back results", QW'(last - first), QW'(count - 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !mem_rd_en, "R1 outputs idle in reset", QW'({out_valid, mem_rd_en}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && !mem_rd_en, "R1 idle after reset", QW'({out_valid, mem_rd_en}), '0);

    for (int v = 0; v < 8; v++) begin
      int a = int'(VEC[v][27:16]);
      int c = int'(VEC[v][15:8]);
      string t = (a & 3) == 0 ? "R2 aligned data" : "R3 merged data";
      if (a + 4 * c > AMASK) t = "R9 wrapped data";
      do_start(a, c);
      collect(a, c, VEC[v][7:0], c, 1'b1, t);
    end

    // R7: zero count
    begin
      int seen = 0;
      do_start(7, 0);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        if (mem_rd_en || out_valid) seen++;
      end
      chk(seen == 0, "R7 zero count is silent", QW'(seen), '0);
    end

    // R6: restart while reads are in flight
    do_start(12'h205, 8);
    collect(12'h205, 8, 8'hFF, 2, 1'b0, "R3 data before restart");
    do_start(12'h332, 3);
    #1;
    chk(!out_valid, "R6 flushed after start", QW'(out_valid), '0);
    collect(12'h332, 3, 8'hFF, 3, 1'b1, "R6 data after restart");

    // R3: offset 1 under alternating backpressure, then wrap with offset 3
    do_start(12'h7F1, 5);
    collect(12'h7F1, 5, 8'hAA, 5, 1'b1, "R3 offset one data");
    do_start(12'hFFB, 2);
    collect(12'hFFB, 2, 8'hFF, 2, 1'b1, "R9 wrap offset three");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule